// File: doc/BRIEF.md
# MDIO Management Master

This block runs management transactions from a MAC to an external PHY over a two-wire management bus. It drives a clock line (MDC) and a bidirectional data line (MDIO). Software hands over one complete, pre-encoded 32-bit frame word. Start, opcode, PHY address, register number, turnaround and data each sit at a fixed bit position in that word. Writing the word to the frame register launches the transaction. The block sends a 32-bit preamble of ones and then the 32 frame bits, most significant bit first. For a read it releases MDIO from the turnaround field onward and collects the 16 data bits that the PHY returns.

MDC is produced from the system clock by a divider. The divider value sits in a small speed register and is chosen so that MDC stays at or below 2.5 MHz. A speed of zero stops MDC and refuses new transactions. Transactions are also refused while the management enable input is low. When a transaction ends, a sticky event flag rises. Software clears it by writing a one to it.

A read command word has the form 0x60020000, and a write command word has the form 0x50020000 with the write data in bits 15..0. In both, the PHY address goes in bits 27..23 and the register number in bits 22..18.

Top module: `mdio_master`

## Requirements
- R1: After a synchronous active-low reset, MDC is low, MDIO is not driven, the event flag is low, and every readable register returns zero.
- R2: Writing the frame register (select 0) starts a transaction when the block is idle, the enable input is high and the speed field S is non-zero. MDC then toggles every S system clocks, with its first rising edge S clocks after the accepting edge. MDC stays low when no transaction is running.
- R3: A transaction has 64 bit slots: 32 preamble ones, then frame bits 31..0, most significant first. The first slot is driven at the start, each later slot is driven when MDC falls, and each slot is held across the next rising edge.
- R4: If frame bits 29..28 equal 2'b10 (read), MDIO is released from the slot of frame bit 17 (turnaround) through the end of the transaction. Any other opcode keeps MDIO driven for all 64 slots.
- R5: For a read, MDIO is sampled on the rising MDC edge of each of the last 16 slots and shifted into bits 15..0 of the frame register, most significant first. Bits 31..16 keep the written word. For a write, the register reads back the word as written.
- R6: The falling MDC edge that ends slot 64 ends the transaction. At that edge MDC is low, MDIO is released, and the event flag (output evt_o, bit 0 of register select 2) becomes one.
- R7: Writing register select 2 with bit 0 = 1 clears the event flag, and bit 0 = 0 leaves it unchanged. A clear that arrives in the same cycle as a completion loses, so the flag stays set.
- R8: The speed register (select 1) holds S in bits 6..1. All of its other bits read zero. While S is zero, a frame write is rejected: the word is not stored and nothing starts.
- R9: While the enable input is low, a frame write is rejected: the word is not stored and nothing starts.
- R10: A frame write during a transaction is ignored. It neither changes the stored word nor disturbs the running frame.
- R11: S is captured when a transaction starts. Speed writes made during a transaction take effect only from the next transaction. Register select 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mgmt_en | input | 1 | Management enable; frame writes are refused while low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select: 0 frame, 1 speed, 2 event |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 32 | Read data for rd_sel (combinational) |
| evt_o | output | 1 | Sticky completion event flag |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO value seen at the pad |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
A bench model computes MDC phase, slot number and drive state from the number of clocks since the accepting edge, and compares them on every cycle. An off-by-one in the divider therefore shows up as an MDC edge one clock early or late, and a wrong shift point shows up as a wrong MDIO bit in some slot. The corner cases the bench targets are these:
- The fastest and slowest dividers (1 and 63). A counter compare that is wrong at these ends would lock MDC or stretch it.
- Read data of 0x8001 and 0xFFFF. An early or late sample would shift these patterns visibly.
- A turnaround released one slot off, which the per-cycle drive check would catch.
- A frame write and a speed write landing mid-transaction. A block that is not locked here would restart or change its rhythm.
- An event clear in exactly the completion cycle. A design that gave the clear priority would lose the event.

// File: rtl/mdio_master_pkg.sv
// Shared definitions for the MDIO management master.
// Holds the register select codes and the read opcode value.
package mdio_master_pkg;

    typedef enum logic [1:0] {
        SEL_FRAME = 2'd0,
        SEL_SPEED = 2'd1,
        SEL_EVENT = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    localparam logic [1:0] OP_READ = 2'b10;

endpackage

// File: rtl/mdio_mdc_gen.sv
// MDC divider for the MDIO master.
// While run is high, MDC toggles every half_div system clocks, starting low.
// The tick outputs flag the cycle before MDC rises or falls.
// Assumes half_div is non-zero and constant while run is high.
module mdio_mdc_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign wrap      = run && (cnt_q == half_div - DIV_W'(1));
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    // Half-period counter and MDC toggle; both are held at zero when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // R2: MDC parks low once the divider stops.
    a_r2_mdc_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

    // R2: the counter never passes the half period.
    a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (run && half_div != '0) |-> (cnt_q < half_div));

endmodule

// File: rtl/mdio_frame_seq.sv
// Frame sequencer for the MDIO master.
// On start it sends PRE_LEN preamble ones, then the frame word MSB first, one
// slot per MDC period, and advances when MDC falls. For a read opcode it
// releases the line from the turnaround slot and flags the data sample points.
// Assumes the ticks come from a divider that runs while busy is high.
module mdio_frame_seq
    import mdio_master_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int FRAME_W = 32,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               rise_tick,
    input  logic               fall_tick,
    output logic               busy,
    output logic               done,
    output logic               line_out,
    output logic               line_oe,
    output logic               cap_valid
);

    localparam int TOTAL     = PRE_LEN + FRAME_W;
    localparam int SLOT_W    = $clog2(TOTAL);
    localparam int DATA_SLOT = TOTAL - DATA_W;
    localparam int TA_SLOT   = DATA_SLOT - 2;
    localparam int OP_HI     = FRAME_W - 3;

    logic [FRAME_W-1:0] shift_q;
    logic [SLOT_W-1:0]  slot_q;
    logic               busy_q;
    logic               read_q;
    logic               in_pre;
    logic               last;

    assign in_pre    = slot_q < SLOT_W'(PRE_LEN);
    assign last      = slot_q == SLOT_W'(TOTAL - 1);
    assign busy      = busy_q;
    assign done      = busy_q && fall_tick && last;
    assign line_out  = busy_q && (in_pre || shift_q[FRAME_W-1]);
    assign line_oe   = busy_q && !(read_q && slot_q >= SLOT_W'(TA_SLOT));
    assign cap_valid = busy_q && rise_tick && read_q && slot_q >= SLOT_W'(DATA_SLOT);

    // Slot counter and frame shifter; the frame only shifts after its own slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            slot_q  <= '0;
            shift_q <= '0;
            read_q  <= 1'b0;
        end else if (start && !busy_q) begin
            busy_q  <= 1'b1;
            slot_q  <= '0;
            shift_q <= frame_in;
            read_q  <= frame_in[OP_HI -: 2] == OP_READ;
        end else if (busy_q && fall_tick) begin
            if (last) begin
                busy_q <= 1'b0;
                slot_q <= '0;
            end else begin
                slot_q <= slot_q + SLOT_W'(1);
            end
            if (!in_pre) begin
                shift_q <= {shift_q[FRAME_W-2:0], 1'b0};
            end
        end
    end

    // R3: every preamble slot drives a one.
    a_r3_preamble_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && in_pre) |-> (line_oe && line_out));

    // R4: the line is never driven while idle.
    a_r4_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !line_oe);

    // R6: the completion pulse ends the transaction.
    a_r6_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy_q);

    // R10: a start during a transaction leaves the direction unchanged.
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start) |=> $stable(read_q));

endmodule

// File: rtl/mdio_master.sv
// MDIO management master top.
// Register port: select 0 frame/data word, 1 speed (S in bits 6..1),
// 2 event flag (bit 0, write one to clear). A frame write starts a
// transaction when idle, enabled and S != 0. Read data fills bits 15..0.
// Assumes a single-cycle write strobe and combinational read data.
module mdio_master
    import mdio_master_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter int DIV_W   = 6,
    parameter int DIV_LSB = 1,
    parameter int PRE_LEN = 32,
    parameter int DATA_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mgmt_en,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic             evt_o,
    output logic             mdc_o,
    input  logic             mdio_i,
    output logic             mdio_o,
    output logic             mdio_oe
);

    localparam int SPD_PAD = REG_W - DIV_W - DIV_LSB;

    logic [REG_W-1:0] frame_q;
    logic [DIV_W-1:0] spd_q;
    logic [DIV_W-1:0] spd_lat;
    logic             evt_q;
    logic             busy;
    logic             done;
    logic             cap_valid;
    logic             rise_tick;
    logic             fall_tick;
    logic             wr_frame;
    logic             accept;
    logic             clr_evt;

    assign wr_frame = wr_en && (wr_sel == SEL_FRAME);
    assign accept   = wr_frame && mgmt_en && !busy && (spd_q != '0);
    assign clr_evt  = wr_en && (wr_sel == SEL_EVENT) && wr_data[0];
    assign evt_o    = evt_q;

    // Frame register: loaded on an accepted write, low half filled by read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (accept) begin
            frame_q <= wr_data;
        end else if (cap_valid) begin
            frame_q[DATA_W-1:0] <= {frame_q[DATA_W-2:0], mdio_i};
        end
    end

    // Speed register, plus the copy that a running transaction uses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spd_q   <= '0;
            spd_lat <= '0;
        end else begin
            if (wr_en && wr_sel == SEL_SPEED) begin
                spd_q <= wr_data[DIV_LSB +: DIV_W];
            end
            if (accept) begin
                spd_lat <= spd_q;
            end
        end
    end

    // Sticky event flag; a completion wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else if (done) begin
            evt_q <= 1'b1;
        end else if (clr_evt) begin
            evt_q <= 1'b0;
        end
    end

    // Read data multiplexer.
    always_comb begin
        case (rd_sel)
            SEL_FRAME: rd_data = frame_q;
            SEL_SPEED: rd_data = {{SPD_PAD{1'b0}}, spd_q, {DIV_LSB{1'b0}}};
            SEL_EVENT: rd_data = {{(REG_W-1){1'b0}}, evt_q};
            default:   rd_data = '0;
        endcase
    end

    mdio_mdc_gen #(
        .DIV_W (DIV_W)
    ) mdc_gen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .half_div  (spd_lat),
        .mdc       (mdc_o),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_seq #(
        .PRE_LEN (PRE_LEN),
        .FRAME_W (REG_W),
        .DATA_W  (DATA_W)
    ) frame_seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .frame_in  (wr_data),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .busy      (busy),
        .done      (done),
        .line_out  (mdio_o),
        .line_oe   (mdio_oe),
        .cap_valid (cap_valid)
    );

    // R6: a completion always leaves the event flag set.
    a_r6_done_sets_evt: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> evt_q);

    // R7: without a clear request the flag holds.
    a_r7_evt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q && !clr_evt) |=> evt_q);

    // R8: with S = 0 a frame write starts nothing.
    a_r8_zero_speed_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_frame && spd_q == '0 && !busy) |=> !busy);

    // R9: with the enable low a frame write starts nothing.
    a_r9_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_frame && !mgmt_en && !busy) |=> !busy);

    // R10: a frame write during a transaction leaves the stored word intact.
    a_r10_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_frame && !cap_valid) |=> $stable(frame_q));

    // R11: the divider in use cannot change mid-transaction.
    a_r11_divider_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(spd_lat));

endmodule

// File: tb/mdio_master_tb_top.sv
// Bench for mdio_master: a timing model computes MDC phase, slot and drive
// state from the clock count since the accepting edge, and a simple PHY
// returns read data. Outputs are compared on every falling clock edge.
module mdio_master_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SLOTS2     = 128;

    logic        clk     = 1'b0;
    logic        rst_n   = 1'b0;
    logic        mgmt_en = 1'b0;
    logic        wr_en   = 1'b0;
    logic [1:0]  wr_sel  = 2'd0;
    logic [31:0] wr_data = 32'h0;
    logic [1:0]  rd_sel  = 2'd0;
    logic [31:0] rd_data;
    logic        evt_o;
    logic        mdc_o;
    logic        mdio_i  = 1'b1;
    logic        mdio_o;
    logic        mdio_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_master dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mgmt_en (mgmt_en),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .evt_o   (evt_o),
        .mdc_o   (mdc_o),
        .mdio_i  (mdio_i),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    // Model state
    longint      cyc     = 0;
    longint      m_s     = 0;
    int          m_h     = 1;
    bit          m_act   = 1'b0;
    bit          m_evt   = 1'b0;
    logic [5:0]  m_speed = 6'd0;
    logic [31:0] m_frame = 32'h0;
    logic [31:0] m_data  = 32'h0;
    logic [15:0] phy_val = 16'h0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Register-level model, advanced on each rising clock edge.
    always @(posedge clk) begin
        bit pre_busy;
        bit fin;
        pre_busy = m_act && ((cyc - m_s) < SLOTS2 * m_h);
        cyc = cyc + 1;
        if (!rst_n) begin
            m_act = 0; m_evt = 0; m_speed = 0; m_data = 0; m_frame = 0;
        end else begin
            fin = m_act && ((cyc - m_s) == SLOTS2 * m_h);
            if (fin) begin
                m_act = 0;
                m_evt = 1;
                if (m_frame[29:28] == 2'b10) m_data[15:0] = phy_val;
            end
            if (wr_en) begin
                case (wr_sel)
                    2'd0: if (!pre_busy && mgmt_en && m_speed != 0) begin
                        m_act = 1; m_s = cyc; m_h = int'(m_speed);
                        m_frame = wr_data; m_data = wr_data;
                    end
                    2'd1: m_speed = wr_data[6:1];
                    2'd2: if (wr_data[0] && !fin) m_evt = 0;
                    default: ;
                endcase
            end
        end
    end

    // Per-cycle comparison and PHY drive, on the falling clock edge.
    always @(negedge clk) begin
        longint n;
        int ph;
        int slot;
        bit busy;
        bit rd_op;
        logic e_mdc, e_oe, e_bit;
        if (rst_n) begin
            n = cyc - m_s;
            busy = m_act && (n < SLOTS2 * m_h);
            rd_op = m_frame[29:28] == 2'b10;
            e_mdc = 0; e_oe = 0; e_bit = 0; slot = 0;
            if (busy) begin
                ph = int'(n / m_h);
                e_mdc = ph[0];
                slot = ph / 2;
                e_oe = !(rd_op && slot >= 46);
                e_bit = (slot < 32) ? 1'b1 : m_frame[63 - slot];
            end
            chk("R2", "mdc", {31'b0, mdc_o}, {31'b0, e_mdc});
            chk("R4", "mdio_oe", {31'b0, mdio_oe}, {31'b0, e_oe});
            if (e_oe) chk("R3", "mdio_o", {31'b0, mdio_o}, {31'b0, e_bit});
            chk("R6", "evt_o", {31'b0, evt_o}, {31'b0, m_evt});
            case (rd_sel)
                2'd0: if (!busy) chk("R5", "frame reg", rd_data, m_data);
                2'd1: chk("R8", "speed reg", rd_data, {25'b0, m_speed, 1'b0});
                2'd2: chk("R7", "event reg", rd_data, {31'b0, m_evt});
                default: chk("R11", "unused select", rd_data, 32'h0);
            endcase
            mdio_i = (busy && rd_op && slot >= 48) ? phy_val[63 - slot] : 1'b1;
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_act) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] rd_cmd(input int phy, input int regn);
        return 32'h6002_0000 | (32'(phy & 31) << 23) | (32'(regn & 31) << 18);
    endfunction

    function automatic logic [31:0] wr_cmd(input int phy, input int regn, input logic [15:0] v);
        return 32'h5002_0000 | (32'(phy & 31) << 23) | (32'(regn & 31) << 18) | {16'h0, v};
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] f;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "mdc", {31'b0, mdc_o}, 32'h0);
        chk("R1", "mdio_oe", {31'b0, mdio_oe}, 32'h0);
        chk("R1", "evt", {31'b0, evt_o}, 32'h0);
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s); #1;
            chk("R1", "reg readback", rd_data, 32'h0);
        end
        rd_sel = 2'd0;
        rst_n = 1'b1;
        mgmt_en = 1'b1;

        // R8: zero speed rejects a frame write
        wr(2'd0, wr_cmd(1, 1, 16'h1234));
        repeat (5) @(negedge clk);
        chk("R8", "word not stored at S=0", rd_data, 32'h0);
        chk("R8", "no drive at S=0", {31'b0, mdio_oe}, 32'h0);

        // R8: speed field placement, stray bits dropped
        wr(2'd1, 32'hFFFF_FF84);
        rd_sel = 2'd1; #1;
        chk("R8", "speed readback", rd_data, 32'h0000_0004);
        rd_sel = 2'd0;

        // R9: enable low rejects a frame write
        mgmt_en = 1'b0;
        wr(2'd0, wr_cmd(2, 2, 16'h5555));
        repeat (6) @(negedge clk);
        chk("R9", "word not stored while disabled", rd_data, 32'h0);
        chk("R9", "mdc idle while disabled", {31'b0, mdc_o}, 32'h0);
        mgmt_en = 1'b1;

        // R2 R3 R6: write transaction at S=2
        f = wr_cmd(5, 3, 16'hBEEF);
        wr(2'd0, f);
        wait_idle();
        chk("R6", "event after write", {31'b0, evt_o}, 32'h1);
        chk("R5", "write word kept", rd_data, f);

        // R7: write zero keeps, write one clears
        wr(2'd2, 32'hFFFF_FFFE);
        chk("R7", "bit0=0 keeps flag", {31'b0, evt_o}, 32'h1);
        wr(2'd2, 32'h1);
        chk("R7", "bit0=1 clears flag", {31'b0, evt_o}, 32'h0);

        // R4 R5: read at S=3
        wr(2'd1, 32'(3 << 1));
        phy_val = 16'hA5C3;
        f = rd_cmd(31, 31);
        wr(2'd0, f);
        wait_idle();
        chk("R5", "read data A5C3", rd_data, {f[31:16], 16'hA5C3});

        // R10 R11: busy write ignored, speed change deferred
        wr(2'd1, 32'(2 << 1));
        phy_val = 16'h8001;
        f = rd_cmd(9, 17);
        wr(2'd0, f);
        repeat (20) @(negedge clk);
        wr(2'd0, wr_cmd(3, 3, 16'h0F0F));
        wr(2'd1, 32'(5 << 1));
        wait_idle();
        chk("R10", "busy write ignored", rd_data, {f[31:16], 16'h8001});
        rd_sel = 2'd1; #1;
        chk("R11", "new speed stored", rd_data, 32'(5 << 1));
        rd_sel = 2'd0;
        wr(2'd0, wr_cmd(0, 0, 16'h0000));
        wait_idle();

        // R2: fastest divider
        wr(2'd1, 32'(1 << 1));
        f = wr_cmd(31, 0, 16'hFFFF);
        wr(2'd0, f);
        wait_idle();
        chk("R5", "write at S=1", rd_data, f);

        // R7: clear in the completion cycle loses
        f = wr_cmd(6, 7, 16'h00FF);
        wr(2'd0, f);
        while (cyc < m_s + SLOTS2 * m_h - 2) @(negedge clk);
        wr(2'd2, 32'h1);
        chk("R7", "completion beats clear", {31'b0, evt_o}, 32'h1);
        wr(2'd2, 32'h1);
        chk("R7", "later clear works", {31'b0, evt_o}, 32'h0);

        // R2 R5: slowest divider, all-ones read
        wr(2'd1, 32'(63 << 1));
        phy_val = 16'hFFFF;
        f = rd_cmd(1, 2);
        wr(2'd0, f);
        wait_idle();
        chk("R5", "read at S=63", rd_data, {f[31:16], 16'hFFFF});
        rd_sel = 2'd3; #1;
        chk("R11", "select 3 reads zero", rd_data, 32'h0);
        rd_sel = 2'd2;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule